// File: doc/BRIEF.md
# Boundary Scan Pin Cell Chain

This block is the data-register path of a test access port for a row of bidirectional pins and a few input-only pins. Each bidirectional pin has three scan stages: one holding output data, one holding output enable, and one that samples the pad. Each input-only pin has a single sampling stage. All stages form one serial chain between a scan input and a scan output. The chain is driven by capture, shift and update strobes that come from a test controller outside the block.

The output-data and output-enable stages each feed an update register. When the external-test mode or the programming mode is active, the pads are driven from these update registers instead of from the core. A high-impedance control input and an active-low test output enable input can each turn off every pad driver, whatever the other settings are. The scan output is retimed on the falling edge of the test clock, so the next device in a board chain sees stable data at its rising edge.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain has 3*NUM_BIDIR+NUM_INPUT stages. Counted from the scan input, bidirectional pin i occupies positions 3i (output data), 3i+1 (output enable) and 3i+2 (pad sample). Input-only pin j sits at position 3*NUM_BIDIR+j, and the last position feeds the scan output. On a rising test-clock edge with shift high, every stage takes the value of its predecessor, and position 0 takes the scan input.
- R2: On a rising edge with capture high and shift low, the stages load, by role: core output data, core output enable, the bidirectional pad value, and the input-only pad value. When shift and capture are both high, shift wins.
- R3: On a rising edge with the update strobe high, the update registers load the data and enable stages of every pin. They keep their value at all other times and clear to 0 on reset.
- R4: While external-test mode is high, each pad's data and enable come from its update registers.
- R5: While programming mode is high, the pads are driven from the update registers exactly as in R4.
- R6: While the high-impedance control is high, every pad enable is 0.
- R7: While the active-low test output enable is 0, every pad enable is 0.
- R8: With both modes low, high-impedance low and test output enable high, each pad's data and enable equal the core's data and enable.
- R9: The scan output changes only on the falling edge of the test clock. After that edge it equals the last chain stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftDr | input | 1 | Shift strobe for the data register |
| captureDr | input | 1 | Capture strobe for the data register |
| updateDr | input | 1 | Update strobe for the data register |
| extest | input | 1 | External-test mode: drive the pads from the update registers |
| progMode | input | 1 | Programming mode: same pad override as extest |
| highZ | input | 1 | Turns off every pad driver |
| testOeN | input | 1 | Active-low test output enable; 0 turns off every pad driver |
| scanIn | input | 1 | Serial data into chain position 0 |
| scanOut | output | 1 | Serial data out, retimed on the falling edge |
| coreOut | input | NUM_BIDIR | Core output data per bidirectional pin |
| coreOe | input | NUM_BIDIR | Core output enable per bidirectional pin |
| padIn | input | NUM_BIDIR | Sampled value of each bidirectional pad |
| inPin | input | NUM_INPUT | Input-only pad values |
| padOut | output | NUM_BIDIR | Data sent to each pad driver |
| padOe | output | NUM_BIDIR | Enable sent to each pad driver |

## Verification
The assertions check the following on every clock:
- the two driver-off overrides and the normal pass-through at the pads;
- the entry of the scan input into position 0 on each shift;
- that the update registers hold whenever no update strobe is present;
- that the scan output mirrors the last stage at each rising edge.

Only the bench's scan scenarios can show the rest:
- the full chain ordering and the capture source of each stage, through read-outs of the whole chain;
- the pad override after a complete shift-and-update sequence;
- the priority of shift over capture;
- the falling-edge timing of the scan output.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef struct packed {
    logic shiftEn;
    logic captureEn;
    logic updateEn;
    logic useScan;
    logic forceOff;
  } bscanStrobes_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic          shiftDr,
  input  logic          captureDr,
  input  logic          updateDr,
  input  logic          extest,
  input  logic          progMode,
  input  logic          highZ,
  input  logic          testOeN,
  output bscanStrobes_t strb
);

  // Shift takes priority over capture (R2)
  always_comb begin
    strb.shiftEn   = shiftDr;
    strb.captureEn = captureDr & ~shiftDr;
    strb.updateEn  = updateDr;
    strb.useScan   = extest | progMode;   // R4, R5
    strb.forceOff  = highZ | ~testOeN;    // R6, R7
  end

endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_INPUT = 2
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  bscanStrobes_t        strb,
  input  logic                 scanIn,
  input  logic [NUM_BIDIR-1:0] coreOut,
  input  logic [NUM_BIDIR-1:0] coreOe,
  input  logic [NUM_BIDIR-1:0] padIn,
  input  logic [NUM_INPUT-1:0] inPin,
  output logic                 scanOut,
  output logic [NUM_BIDIR-1:0] padOut,
  output logic [NUM_BIDIR-1:0] padOe
);

  localparam int BIDIR_LEN = 3 * NUM_BIDIR;
  localparam int CHAIN_LEN = BIDIR_LEN + NUM_INPUT;

  logic [CHAIN_LEN-1:0] chainQ;
  logic [CHAIN_LEN-1:0] captureSrc;
  logic [CHAIN_LEN-1:0] chainNext;
  logic [NUM_BIDIR-1:0] updData;
  logic [NUM_BIDIR-1:0] updOe;
  logic [NUM_BIDIR-1:0] scanData;
  logic [NUM_BIDIR-1:0] scanOe;

  // Per-pin stage mapping: data, enable, pad sample (R1, R2)
  for (genvar i = 0; i < NUM_BIDIR; i++) begin : g_bidir
    assign captureSrc[3*i]     = coreOut[i];
    assign captureSrc[3*i + 1] = coreOe[i];
    assign captureSrc[3*i + 2] = padIn[i];
    assign scanData[i]         = chainQ[3*i];
    assign scanOe[i]           = chainQ[3*i + 1];
  end

  // Input-only cells: a single stage, no update register
  for (genvar j = 0; j < NUM_INPUT; j++) begin : g_input
    assign captureSrc[BIDIR_LEN + j] = inPin[j];
  end

  always_comb begin
    if (strb.shiftEn)
      chainNext = {chainQ[CHAIN_LEN-2:0], scanIn};
    else if (strb.captureEn)
      chainNext = captureSrc;
    else
      chainNext = chainQ;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= chainNext;
  end

  // Update registers (R3)
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      updData <= '0;
      updOe   <= '0;
    end else if (strb.updateEn) begin
      updData <= scanData;
      updOe   <= scanOe;
    end
  end

  // Scan output retimed on the falling edge (R9)
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) scanOut <= 1'b0;
    else       scanOut <= chainQ[CHAIN_LEN-1];
  end

  // Pad drive selection (R4..R8)
  always_comb begin
    for (int i = 0; i < NUM_BIDIR; i++) begin
      padOut[i] = strb.useScan ? updData[i] : coreOut[i];
      padOe[i]  = (strb.useScan ? updOe[i] : coreOe[i]) & ~strb.forceOff;
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!rstN)
    strb.shiftEn |=> chainQ[0] == $past(scanIn)); // R1

  AST_UPDATE_HOLD: assert property (@(posedge tck) disable iff (!rstN)
    !strb.updateEn |=> $stable(updData) && $stable(updOe)); // R3

  AST_SCANOUT_RETIMED: assert property (@(posedge tck) disable iff (!rstN)
    scanOut == chainQ[CHAIN_LEN-1]); // R9

endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
  import bscan_pkg::*;
#(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_INPUT = 2
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  logic                 shiftDr,
  input  logic                 captureDr,
  input  logic                 updateDr,
  input  logic                 extest,
  input  logic                 progMode,
  input  logic                 highZ,
  input  logic                 testOeN,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic [NUM_BIDIR-1:0] coreOut,
  input  logic [NUM_BIDIR-1:0] coreOe,
  input  logic [NUM_BIDIR-1:0] padIn,
  input  logic [NUM_INPUT-1:0] inPin,
  output logic [NUM_BIDIR-1:0] padOut,
  output logic [NUM_BIDIR-1:0] padOe
);

  bscanStrobes_t strb;

  bscan_ctrl u_ctrl (
    .shiftDr  (shiftDr),
    .captureDr(captureDr),
    .updateDr (updateDr),
    .extest   (extest),
    .progMode (progMode),
    .highZ    (highZ),
    .testOeN  (testOeN),
    .strb     (strb)
  );

  bscan_datapath #(
    .NUM_BIDIR(NUM_BIDIR),
    .NUM_INPUT(NUM_INPUT)
  ) u_dp (
    .tck       (tck),
    .rstN      (rstN),
    .strb      (strb),
    .scanIn    (scanIn),
    .coreOut   (coreOut),
    .coreOe    (coreOe),
    .padIn     (padIn),
    .inPin     (inPin),
    .scanOut   (scanOut),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  AST_HIGHZ_OFF: assert property (@(posedge tck) disable iff (!rstN)
    highZ |-> padOe == '0); // R6

  AST_TOE_OFF: assert property (@(posedge tck) disable iff (!rstN)
    !testOeN |-> padOe == '0); // R7

  AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (!rstN)
    (!extest && !progMode && !highZ && testOeN) |->
      (padOut == coreOut && padOe == coreOe)); // R8

endmodule

// File: tb/bscan_pin_chain_bench.sv
module bscan_pin_chain_bench;

  localparam int NB = 4;
  localparam int NI = 2;
  localparam int L  = 3 * NB + NI;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic shiftDr = 0, captureDr = 0, updateDr = 0;
  logic extest = 0, progMode = 0, highZ = 0, testOeN = 1;
  logic scanIn = 0;
  logic scanOut;
  logic [NB-1:0] coreOut = '0, coreOe = '0, padIn = '0;
  logic [NI-1:0] inPin = '0;
  logic [NB-1:0] padOut, padOe;

  int checks = 0;
  int failures = 0;
  logic [NB-1:0] mdlData = '0, mdlOe = '0;

  always #4 tck = ~tck;

  bscan_pin_chain #(.NUM_BIDIR(NB), .NUM_INPUT(NI)) u_bscan_pin_chain (
    .tck(tck), .rstN(rstN), .shiftDr(shiftDr), .captureDr(captureDr),
    .updateDr(updateDr), .extest(extest), .progMode(progMode),
    .highZ(highZ), .testOeN(testOeN), .scanIn(scanIn), .scanOut(scanOut),
    .coreOut(coreOut), .coreOe(coreOe), .padIn(padIn), .inPin(inPin),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] expCapture();
    logic [L-1:0] v;
    for (int i = 0; i < NB; i++) begin
      v[3*i] = coreOut[i]; v[3*i+1] = coreOe[i]; v[3*i+2] = padIn[i];
    end
    for (int j = 0; j < NI; j++) v[3*NB+j] = inPin[j];
    return v;
  endfunction

  function automatic logic [2*NB-1:0] expPins();
    logic [NB-1:0] o, e;
    bit useScan = extest | progMode;
    o = useScan ? mdlData : coreOut;
    e = (useScan ? mdlOe : coreOe) & {NB{~highZ & testOeN}};
    return {o, e};
  endfunction

  task automatic checkPins(input string req);
    logic [2*NB-1:0] exp;
    #1;
    exp = expPins();
    check({padOut, padOe} == exp, req, {padOut, padOe}, exp);
  endtask

  // Called just after a falling edge
  task automatic doCapture();
    captureDr = 1;
    @(posedge tck); @(negedge tck); #1;
    captureDr = 0;
  endtask

  task automatic doUpdate(input logic [L-1:0] chainVal);
    updateDr = 1;
    @(posedge tck); @(negedge tck); #1;
    updateDr = 0;
    for (int i = 0; i < NB; i++) begin
      mdlData[i] = chainVal[3*i];
      mdlOe[i]   = chainVal[3*i+1];
    end
  endtask

  task automatic scanOp(input logic [L-1:0] want, input bit alsoCap,
                        output logic [L-1:0] got);
    for (int k = 0; k < L; k++) begin
      got[L-1-k] = scanOut;
      shiftDr = 1; captureDr = alsoCap; scanIn = want[L-1-k];
      @(posedge tck); #1;
      check(scanOut == got[L-1-k], "R9 held until falling edge", scanOut, got[L-1-k]);
      @(negedge tck); #1;
    end
    shiftDr = 0; captureDr = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [L-1:0] want, got, want2, expV;
    void'($urandom(32'h5eed_1149));
    repeat (3) @(negedge tck);
    rstN = 1;
    @(negedge tck); #1;

    // R3: update registers cleared at reset
    extest = 1;
    checkPins("R3 reset clears update regs");
    check(scanOut == 1'b0, "R9 reset scanOut", scanOut, 0);
    extest = 0;

    // R1: pure shift round trip through every stage incl. input-only
    want = L'(32'h2A5D);
    scanOp(want, 0, got);
    want2 = L'(32'h13C6);
    scanOp(want2, 0, got);
    check(got == want, "R1 chain round trip", got, want);

    for (int it = 0; it < 24; it++) begin
      extest = 0; progMode = 0; highZ = 0; testOeN = 1;
      coreOut = NB'($urandom); coreOe = NB'($urandom);
      padIn = NB'($urandom); inPin = NI'($urandom);
      want = L'($urandom);
      doCapture();
      expV = expCapture();
      scanOp(want, (it % 5) == 0, got);
      check(got == expV, "R1 R2 capture readout order", got, expV);
      checkPins("R8 normal pass-through");
      extest = 1;
      checkPins("R3 hold without update");
      extest = 0;
      if ((it % 5) == 0) begin
        // shift had priority over capture: chain holds shifted data
        doUpdate(want);
        extest = 1;
        checkPins("R2 shift wins over capture");
        extest = 0;
      end else begin
        doUpdate(want);
      end
      extest = 1; checkPins("R4 extest drives update regs");
      extest = 0; progMode = 1; checkPins("R5 prog mode drives update regs");
      highZ = 1; checkPins("R6 highZ turns drivers off");
      highZ = 0; testOeN = 0; checkPins("R7 test OE low turns drivers off");
      extest = 0; progMode = 0; highZ = 1; testOeN = 1;
      checkPins("R6 highZ over core enable");
      highZ = $urandom_range(0, 1); testOeN = $urandom_range(0, 1);
      extest = $urandom_range(0, 1); progMode = $urandom_range(0, 1);
      checkPins("R4 R5 R6 R7 R8 random mode mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule